// File: doc/BRIEF.md
# Three-Size Translation Buffer with Decaying-Frequency Replacement

This block caches virtual-to-physical translations for three page granularities: 4 KiB, 2 MiB and 1 GiB. Each granularity has its own entry array. The smallest-page array is the deepest. The page size of an incoming 64-bit virtual address is unknown when it arrives, so every lookup is compared against all three arrays at once. One cycle later the block returns a response flag, a hit flag, a size code and the 64-bit physical address.

A page walker outside the block supplies fills. Each fill carries the virtual page number, the physical frame number and the resolved size. The fill lands in the array for that size.

Every entry keeps a small use counter. A hit raises the counter. A periodic decay halves all counters, so entries that were busy long ago lose their claim. When an array is full, the entry with the smallest count is replaced. A flush input empties all three arrays.

Top module: `tlb_lfu3`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` is low, and any lookup misses.
- R2: A lookup presented with `lk_valid` high on one clock edge produces `rsp_valid` high on the next edge, and only then.
- R3: Size code 0 (4 KiB) matches on VA[63:12]. On a hit, PA = {stored frame[51:0], VA[11:0]}.
- R4: Size code 1 (2 MiB) matches on VA[63:21]. On a hit, PA = {stored frame[51:9], VA[20:0]}. Low frame bits given at fill are ignored.
- R5: Size code 2 (1 GiB) matches on VA[63:30]. On a hit, PA = {stored frame[51:18], VA[29:0]}.
- R6: A miss returns `rsp_hit`=0, `rsp_size`=0 and `rsp_pa`=0.
- R7: When more than one array hits, the smallest page size is reported.
- R8: A fill and a lookup in the same cycle are both accepted. The lookup sees the contents from before the fill.
- R9: A fill goes to the lowest-indexed invalid entry of its array if one exists.
- R10: In a full array, a fill replaces the entry with the smallest use count, taking the lowest index on a tie.
- R10 (counters): A new entry starts at 1. Each hit adds 1 and saturates at 15.
- R11: On every 256th lookup since reset, all use counters are halved, after that lookup's own increment.
- R12: Flush invalidates every entry in one cycle. A fill in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| fill_valid | input | 1 | Fill request |
| fill_size | input | 2 | Fill page size: 0=4 KiB, 1=2 MiB, 2=1 GiB |
| fill_vpn | input | 52 | Fill virtual page number, VA[63:12] |
| fill_pfn | input | 52 | Fill physical frame number, PA[63:12] |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_size | output | 2 | Size code of the hit |
| rsp_pa | output | 64 | Translated physical address |

## Verification
Lookups are issued at addresses inside each page size. Offsets use non-zero low bits, which shows whether the right number of untranslated bits pass through. Fill frames carry stray low bits, which shows whether they are masked.

A 4 KiB page placed inside a mapped 2 MiB region checks the size priority. Lookups with a fill in the same cycle, and a flush with a fill in the same cycle, check the ordering rules.

Replacement is tested with fill sequences under several conditions:
- all counts tied;
- one entry with a lower count;
- a counter pushed past 15;
- counts spanning a decay boundary.

Each sequence tells apart the min-count, tie-break, saturation and halving rules.

// File: rtl/tlb_lfu3.sv
module tlb_lfu3 #(
  parameter int N4K = 8,
  parameter int N2M = 4,
  parameter int N1G = 2,
  parameter int CW = 4,
  parameter int DECAY_LOOKUPS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        lk_valid,
  input  logic [63:0] lk_va,
  input  logic        fill_valid,
  input  logic [1:0]  fill_size,
  input  logic [51:0] fill_vpn,
  input  logic [51:0] fill_pfn,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [1:0]  rsp_size,
  output logic [63:0] rsp_pa
);
  localparam int DW = (DECAY_LOOKUPS > 1) ? $clog2(DECAY_LOOKUPS) : 1;

  logic [DW-1:0] dcnt;
  logic          decay;
  logic [2:0]    g_hit;
  logic [63:0]   g_pa [3];

  assign decay = lk_valid && (dcnt == DW'(DECAY_LOOKUPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt <= '0;
    else if (decay) dcnt <= '0;
    else if (lk_valid) dcnt <= dcnt + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_arr
    localparam int D = (g == 0) ? N4K : (g == 1) ? N2M : N1G;
    localparam int IW = $clog2(D);
    localparam logic [51:0] HM = {52{1'b1}} << (9 * g);

    logic [D-1:0]    vld;
    logic [D-1:0]    hv;
    logic [51:0]     tag   [D];
    logic [51:0]     frame [D];
    logic [CW-1:0]   cnt   [D];
    logic [CW-1:0]   cnt_nx[D];
    logic [51:0]     sel;
    logic [IW-1:0]   vic;
    logic [CW-1:0]   best;
    logic            got_inv;
    logic            wr;

    assign wr = fill_valid && (fill_size == 2'(g));

    always_comb begin
      sel = '0;
      for (int i = 0; i < D; i++) begin
        hv[i] = vld[i] && (((tag[i] ^ lk_va[63:12]) & HM) == '0);
        if (hv[i]) sel = sel | frame[i];
        cnt_nx[i] = cnt[i] + CW'(lk_valid && hv[i] && (cnt[i] != '1));
        if (decay) cnt_nx[i] = cnt_nx[i] >> 1;
      end
    end

    always_comb begin
      got_inv = 1'b0;
      vic = '0;
      best = cnt[0];
      for (int i = 0; i < D; i++)
        if (!vld[i] && !got_inv) begin
          got_inv = 1'b1;
          vic = IW'(i);
        end
      if (!got_inv)
        for (int i = 1; i < D; i++)
          if (cnt[i] < best) begin
            best = cnt[i];
            vic = IW'(i);
          end
    end

    assign g_hit[g] = |hv;
    assign g_pa[g] = {(sel & HM) | (lk_va[63:12] & ~HM), lk_va[11:0]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= '0;
        for (int i = 0; i < D; i++) cnt[i] <= '0;
      end else if (flush) begin
        vld <= '0;
        for (int i = 0; i < D; i++) cnt[i] <= cnt_nx[i];
      end else begin
        for (int i = 0; i < D; i++) cnt[i] <= cnt_nx[i];
        if (wr) begin
          vld[vic]   <= 1'b1;
          tag[vic]   <= fill_vpn & HM;
          frame[vic] <= fill_pfn & HM;
          cnt[vic]   <= CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_size  <= 2'd0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|g_hit);
      if (lk_valid && g_hit[0]) begin
        rsp_size <= 2'd0; rsp_pa <= g_pa[0];
      end else if (lk_valid && g_hit[1]) begin
        rsp_size <= 2'd1; rsp_pa <= g_pa[1];
      end else if (lk_valid && g_hit[2]) begin
        rsp_size <= 2'd2; rsp_pa <= g_pa[2];
      end else begin
        rsp_size <= 2'd0; rsp_pa <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb_lfu3_chk.sv
module tlb_lfu3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        lk_valid,
  input logic [63:0] lk_va,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [1:0]  rsp_size,
  input logic [63:0] rsp_pa
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_size == 2'd0));
  p_off4k_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_hit -> rsp_pa[11:0] == $past(lk_va[11:0])));
  p_off2m_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ((rsp_hit && rsp_size == 2'd1) -> rsp_pa[20:0] == $past(lk_va[20:0])));
  p_off1g_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ((rsp_hit && rsp_size == 2'd2) -> rsp_pa[29:0] == $past(lk_va[29:0])));
  p_size_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_size != 2'd3);
  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !lk_valid) |=> (lk_valid |=> !rsp_hit));
endmodule

bind tlb_lfu3 tlb_lfu3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_va(lk_va),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_size(rsp_size), .rsp_pa(rsp_pa)
);

// File: tb/tlb_lfu3_bench.sv
`timescale 1ns/1ps
module tlb_lfu3_bench;
  logic clk = 0, rst_n = 0, flush = 0, lk_valid = 0, fill_valid = 0;
  logic [63:0] lk_va = '0;
  logic [1:0]  fill_size = '0;
  logic [51:0] fill_vpn = '0, fill_pfn = '0;
  logic rsp_valid, rsp_hit;
  logic [1:0] rsp_size;
  logic [63:0] rsp_pa;

  always #2 clk = ~clk;

  tlb_lfu3 u_tlb_lfu3 (.*);

  int checks = 0, fails = 0, n_lk = 0;
  bit done = 0;
  logic [66:0] exp_q[$];
  string req_q[$];

  localparam logic [63:0] MISS = 64'hFFFF_F000_0000_0000;

  task automatic chk(string r, logic [66:0] act, logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] pa4(logic [63:0] va, logic [51:0] f); return {f, va[11:0]}; endfunction
  function automatic logic [63:0] pa2(logic [63:0] va, logic [51:0] f); return {f[51:9], va[20:0]}; endfunction
  function automatic logic [63:0] pa1(logic [63:0] va, logic [51:0] f); return {f[51:18], va[29:0]}; endfunction

  task automatic look(logic [63:0] va, logic h, logic [1:0] s, logic [63:0] pa, string r);
    lk_valid = 1; lk_va = va; n_lk++;
    exp_q.push_back({h, s, pa}); req_q.push_back(r);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic miss(logic [63:0] va, string r);
    look(va, 1'b0, 2'd0, 64'd0, r);
  endtask

  task automatic fill(logic [1:0] s, logic [63:0] va, logic [51:0] f);
    fill_valid = 1; fill_size = s; fill_vpn = va[63:12]; fill_pfn = f;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic pad();
    while (n_lk % 256 != 0) miss(MISS | 64'(n_lk << 12), "R11 pad");
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=unexpected response expected=none");
      end else begin
        automatic logic [66:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk(r, {rsp_hit, rsp_size, rsp_pa}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] va_a, va_b, va_c, va_d, va_e;
    logic [51:0] pf_a, pf_b, pf_c, pf_r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {66'd0, rsp_valid}, 67'd0);
    miss(64'h0000_1234_5678_9ABC, "R1 lookup after reset");

    va_a = 64'h0000_1234_5678_9000; pf_a = 52'hA_BCDE_F012_3456;
    fill(2'd0, va_a, pf_a);
    look(va_a | 64'hABC, 1'b1, 2'd0, pa4(va_a | 64'hABC, pf_a), "R3 4K hit");
    @(negedge clk);
    chk("R2 idle cycle", {66'd0, rsp_valid}, 67'd0);
    miss(va_a + 64'h1000, "R3 neighbour page");

    va_b = 64'h0000_00AB_C020_0000; pf_b = 52'h0_0000_1234_55FF;
    fill(2'd1, va_b, pf_b);
    look(va_b + 64'h1_2345, 1'b1, 2'd1, pa2(va_b + 64'h1_2345, pf_b), "R4 2M hit");
    look(va_b + 64'h1F_FFFF, 1'b1, 2'd1, pa2(va_b + 64'h1F_FFFF, pf_b), "R4 2M top");

    va_c = 64'h0000_7F80_4000_0000; pf_c = 52'h0_0012_3FFF_FFFF;
    fill(2'd2, va_c, pf_c);
    look(va_c + 64'h2ABC_DEF1, 1'b1, 2'd2, pa1(va_c + 64'h2ABC_DEF1, pf_c), "R5 1G hit");
    miss(va_c + 64'h4000_0000, "R6 miss");

    pf_r = 52'h5_5555_0000_0777;
    fill(2'd0, va_b + 64'h3000, pf_r);
    look(va_b + 64'h3010, 1'b1, 2'd0, pa4(va_b + 64'h3010, pf_r), "R7 overlap smallest");
    look(va_b + 64'h5010, 1'b1, 2'd1, pa2(va_b + 64'h5010, pf_b), "R7 outside small");

    va_d = 64'h0000_0042_0000_7000;
    fill_valid = 1; fill_size = 2'd0; fill_vpn = va_d[63:12]; fill_pfn = 52'h1;
    look(va_d, 1'b0, 2'd0, 64'd0, "R8 same-cycle lookup misses");
    fill_valid = 0;
    look(va_d | 64'h8, 1'b1, 2'd0, pa4(va_d | 64'h8, 52'h1), "R8 next lookup hits");

    va_e = 64'h0000_0055_0000_1000;
    flush = 1; fill_valid = 1; fill_size = 2'd0; fill_vpn = va_e[63:12]; fill_pfn = 52'h2;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    miss(va_e, "R12 fill dropped");
    miss(va_a, "R12 4K gone");
    miss(va_b, "R12 2M gone");
    miss(va_c, "R12 1G gone");

    for (int i = 0; i < 3; i++) fill(2'd0, 64'h0000_0100_0000_0000 + 64'(i << 12), 52'(i + 16));
    for (int i = 0; i < 3; i++)
      look(64'h0000_0100_0000_0000 + 64'(i << 12), 1'b1, 2'd0,
           pa4(64'h0000_0100_0000_0000 + 64'(i << 12), 52'(i + 16)), "R9 invalid first");

    do_flush();
    for (int i = 0; i < 8; i++) fill(2'd0, 64'h0000_0200_0000_0000 + 64'(i << 12), 52'(i + 32));
    fill(2'd0, 64'h0000_0200_0000_8000, 52'h99);
    miss(64'h0000_0200_0000_0000, "R10 tie evicts index 0");
    look(64'h0000_0200_0000_1000, 1'b1, 2'd0, pa4(64'h0000_0200_0000_1000, 52'd33), "R10 tie keeps 1");
    look(64'h0000_0200_0000_8000, 1'b1, 2'd0, pa4(64'h0000_0200_0000_8000, 52'h99), "R10 tie new");

    do_flush();
    for (int i = 0; i < 8; i++) fill(2'd0, 64'h0000_0300_0000_0000 + 64'(i << 12), 52'(i + 48));
    for (int i = 0; i < 8; i++)
      if (i != 5)
        look(64'h0000_0300_0000_0000 + 64'(i << 12), 1'b1, 2'd0,
             pa4(64'h0000_0300_0000_0000 + 64'(i << 12), 52'(i + 48)), "R10 warm");
    fill(2'd0, 64'h0000_0300_0000_9000, 52'h77);
    miss(64'h0000_0300_0000_5000, "R10 least used evicted");
    look(64'h0000_0300_0000_9000, 1'b1, 2'd0, pa4(64'h0000_0300_0000_9000, 52'h77), "R10 new entry");
    look(64'h0000_0300_0000_4000, 1'b1, 2'd0, pa4(64'h0000_0300_0000_4000, 52'd52), "R10 others kept");

    pad();
    do_flush();
    fill(2'd2, 64'h0000_1000_0000_0000, 52'h100000);
    fill(2'd2, 64'h0000_1000_4000_0000, 52'h140000);
    for (int i = 0; i < 15; i++)
      look(64'h0000_1000_0000_0010, 1'b1, 2'd2, pa1(64'h0000_1000_0000_0010, 52'h100000), "R10 sat warm");
    for (int i = 0; i < 3; i++)
      look(64'h0000_1000_4000_0010, 1'b1, 2'd2, pa1(64'h0000_1000_4000_0010, 52'h140000), "R10 sat warm");
    fill(2'd2, 64'h0000_1000_8000_0000, 52'h180000);
    miss(64'h0000_1000_4000_0000, "R10 saturated entry kept, other evicted");
    look(64'h0000_1000_0000_0000, 1'b1, 2'd2, pa1(64'h0000_1000_0000_0000, 52'h100000), "R10 saturation");
    look(64'h0000_1000_8000_0000, 1'b1, 2'd2, pa1(64'h0000_1000_8000_0000, 52'h180000), "R10 sat new");

    pad();
    do_flush();
    fill(2'd2, 64'h0000_2000_0000_0000, 52'h100000);
    fill(2'd2, 64'h0000_2000_4000_0000, 52'h140000);
    for (int i = 0; i < 15; i++)
      look(64'h0000_2000_0000_0000, 1'b1, 2'd2, pa1(64'h0000_2000_0000_0000, 52'h100000), "R11 warm");
    pad();
    for (int i = 0; i < 8; i++)
      look(64'h0000_2000_4000_0000, 1'b1, 2'd2, pa1(64'h0000_2000_4000_0000, 52'h140000), "R11 warm");
    fill(2'd2, 64'h0000_2000_8000_0000, 52'h180000);
    miss(64'h0000_2000_0000_0000, "R11 decayed entry evicted");
    look(64'h0000_2000_4000_0000, 1'b1, 2'd2, pa1(64'h0000_2000_4000_0000, 52'h140000), "R11 recent kept");
    look(64'h0000_2000_8000_0000, 1'b1, 2'd2, pa1(64'h0000_2000_8000_0000, 52'h180000), "R11 new");

    repeat (4) @(negedge clk);
    chk("R2 all responses seen", 67'(exp_q.size()), 67'd0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule